// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a watchdog that counts pulses from an external hundred-millisecond timebase. Software controls it through a single byte-wide control register. Three action bits in that register enable counting, disable counting and restart the count. None of them acts on a plain write. An action fires only when software first stores a 1 in its bit and then, on a later write, stores a 0 there. A stray single write therefore cannot switch the watchdog off or keep it alive.

The low five bits give the timeout N. Software cannot line up a restart with the timebase, so the tick after a restart covers only part of an interval. For that reason expiry falls between N+1 and N+2 full tick periods after the restart. On expiry the block raises one of two request lines, chosen by an external mode input: a system reset request or an interrupt request. The request stays raised until software restarts or disables the watchdog. The reset and interrupt controllers that consume these lines are outside the block.

Top module: `wdog_seq_timer`

## Requirements
- R1: After a synchronous reset the control register reads 0x00, counting is disabled, the tick count is zero and both request outputs are low. `ctrl_rdata` always returns the last value written.
- R2: The enable action sets the counting flag. A write of 1 to bit 7 alone, or repeated writes of 1, does nothing.
- R3: The disable action (bit 6) clears the counting flag, the tick count and any pending request. If the enable and disable actions fire in the same write, disable wins.
- R4: The restart action (bit 5) clears the tick count and any pending request. It takes priority over a tick that arrives in the same cycle.
- R5: The tick count advances by one only on a cycle with `tick_in` high, the counting flag set and no request pending. Otherwise it holds.
- R6: With N in bits 4:0, the request rises on the (N+2)-th counted tick after a restart or clear and never earlier. For example, N=0 gives the 2nd tick, N=3 the 5th and N=31 the 33rd.
- R7: The mode level sampled on the expiring cycle picks the output. A 1 raises `rst_req` and a 0 raises `irq_req`. The two are never high together, and changing the mode later does not move a pending request.
- R8: A raised request holds through any further ticks until a restart or disable action.
- R9: An action fires on a write only when the stored bit is 1 and the written bit is 0. The patterns 0→1, 1→1 and 0→0 fire nothing, and neither do cycles with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Write data: bit 7 enable, bit 6 disable, bit 5 restart, bits 4:0 timeout N |
| ctrl_rdata | output | 8 | Current control register value |
| tick_in | input | 1 | One-cycle pulse per hundred-millisecond timebase interval |
| mode_rst | input | 1 | Expiry action select: 1 reset request, 0 interrupt request |
| rst_req | output | 1 | Registered system reset request |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The assertions check on every cycle that the two requests are never high together, that a pending request survives until an action clears it, and that a restart leaves the count and the requests clear on the next cycle. They also check that the count holds while disabled and that a request rises only on a tick whose count has reached the limit. The bench scenarios show the things that depend on a whole history of writes and ticks. These are the exact tick on which expiry lands for N = 0, 3 and 31, that a plain or repeated write of 1 does nothing, that disable wins over enable in the same write, and that a restart which collides with a tick still buys a full window.

// File: rtl/wdog_seq_pkg.sv
package wdog_seq_pkg;
  localparam int CNT_W  = 5;
  localparam int REG_W  = CNT_W + 3;
  localparam int B_EN   = REG_W - 1;
  localparam int B_DIS  = REG_W - 2;
  localparam int B_RST  = REG_W - 3;
  localparam int NUM_ACT = 3;

  typedef struct packed {
    logic enable;
    logic disable_;
    logic restart;
  } wdog_act_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_seq_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output wdog_act_t     act
);
  localparam int ACT_LO = DW - NUM_ACT;

  logic [NUM_ACT-1:0] fall;

  // An action bit fires when the stored 1 is overwritten with a 0
  for (genvar g = 0; g < NUM_ACT; g++) begin : g_fall
    assign fall[g] = we & ctrl_q[ACT_LO+g] & ~wdata[ACT_LO+g];
  end

  assign act.enable   = fall[NUM_ACT-1];
  assign act.disable_ = fall[NUM_ACT-2];
  assign act.restart  = fall[NUM_ACT-3];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q <= wdata;
    end
  end
endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
  import wdog_seq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic        clk,
  input  logic        rst,
  input  wdog_act_t   act,
  input  logic        tick,
  input  logic [CW-1:0] limit_n,
  input  logic        pending,
  output logic        en_q,
  output logic [CW:0] cnt_q,
  output logic        expire
);
  localparam int TW = CW + 1;

  logic [TW-1:0] limit;
  logic          clr;
  logic          adv;

  assign limit  = {1'b0, limit_n} + TW'(1);
  assign clr    = act.restart | act.disable_;
  assign adv    = en_q & tick & ~pending;
  // Terminal tick: count already at N+1, so this is tick N+2 after a clear
  assign expire = adv & ~clr & (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (act.disable_) begin
      en_q <= 1'b0;
    end else if (act.enable) begin
      en_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (adv && (cnt_q != limit)) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/wdog_req_out.sv
module wdog_req_out
  import wdog_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  wdog_act_t act,
  input  logic      expire,
  input  logic      mode_rst,
  output logic      rst_req,
  output logic      irq_req
);
  always_ff @(posedge clk) begin
    if (rst || act.restart || act.disable_) begin
      rst_req <= 1'b0;
      irq_req <= 1'b0;
    end else if (expire) begin
      rst_req <= mode_rst;
      irq_req <= ~mode_rst;
    end
  end
endmodule

// File: rtl/wdog_seq_timer.sv
module wdog_seq_timer
  import wdog_seq_pkg::*;
#(
  parameter int CW = CNT_W,
  localparam int DW = CW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [DW-1:0] ctrl_wdata,
  output logic [DW-1:0] ctrl_rdata,
  input  logic          tick_in,
  input  logic          mode_rst,
  output logic          rst_req,
  output logic          irq_req
);
  wdog_act_t   act;
  logic [DW-1:0] ctrl_q;
  logic        en_q;
  logic [CW:0] cnt_q;
  logic        expire;
  logic        pending;

  assign ctrl_rdata = ctrl_q;
  assign pending    = rst_req | irq_req;

  wdog_ctrl_reg #(.DW(DW)) u_reg (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(ctrl_wdata),
    .ctrl_q(ctrl_q), .act(act)
  );

  wdog_tick_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .act(act), .tick(tick_in),
    .limit_n(ctrl_q[CW-1:0]), .pending(pending),
    .en_q(en_q), .cnt_q(cnt_q), .expire(expire)
  );

  wdog_req_out u_out (
    .clk(clk), .rst(rst), .act(act), .expire(expire),
    .mode_rst(mode_rst), .rst_req(rst_req), .irq_req(irq_req)
  );
endmodule

// File: rtl/wdog_seq_timer_chk.sv
module wdog_seq_timer_chk
  import wdog_seq_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input logic        clk,
  input logic        rst,
  input logic        tick_in,
  input logic        rst_req,
  input logic        irq_req,
  input logic        en_q,
  input logic [CW:0] cnt_q,
  input logic [CW-1:0] limit_n,
  input wdog_act_t   act
);
  logic clr;
  assign clr = act.restart | act.disable_;

  // R7
  a_r7_one_request: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && irq_req));

  // R8
  a_r8_irq_held: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !clr) |=> irq_req);
  a_r8_rst_held: assert property (@(posedge clk) disable iff (rst)
    (rst_req && !clr) |=> rst_req);

  // R4
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
    act.restart |=> (cnt_q == '0 && !rst_req && !irq_req));

  // R5
  a_r5_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !clr) |=> $stable(cnt_q));

  // R6
  a_r6_no_early_expiry: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req || irq_req) |->
      $past(tick_in && (cnt_q == ({1'b0, limit_n} + 1'b1))));
endmodule

bind wdog_seq_timer wdog_seq_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick_in(tick_in), .rst_req(rst_req),
  .irq_req(irq_req), .en_q(en_q), .cnt_q(cnt_q),
  .limit_n(ctrl_q[CW-1:0]), .act(act)
);

// File: tb/test_wdog_seq_timer.sv
module test_wdog_seq_timer;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       rst_req;
    logic       irq_req;
    logic [7:0] rdata;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       tick_in = 1'b0;
  logic       mode_rst = 1'b0;
  logic       rst_req;
  logic       irq_req;

  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;
  logic [7:0] shadow = 8'h00;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_seq_timer i_wdog_seq_timer (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .tick_in(tick_in), .mode_rst(mode_rst),
    .rst_req(rst_req), .irq_req(irq_req)
  );

  task automatic step(input logic wr, input logic [7:0] d, input logic tk);
    @(negedge clk);
    ctrl_we = wr; ctrl_wdata = d; tick_in = tk;
    @(posedge clk);
    #1;
    if (wr) shadow = d;
    ctrl_we = 1'b0; tick_in = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    step(1'b1, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1);
  endtask

  task automatic expect_out(input logic r, input logic i, input string tag);
    exp_t e;
    e.rst_req = r; e.irq_req = i; e.rdata = shadow; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rst_req !== e.rst_req || irq_req !== e.irq_req || ctrl_rdata !== e.rdata) begin
        fails++;
        $display("FAIL %s: got rst_req=%b irq_req=%b rdata=%h, expected rst_req=%b irq_req=%b rdata=%h",
                 e.tag, rst_req, irq_req, ctrl_rdata, e.rst_req, e.irq_req, e.rdata);
      end
    end
  end

  initial begin
    repeat (3) step(1'b0, 8'h00, 1'b0);
    rst = 1'b0;
    expect_out(0, 0, "R1 reset state");

    wr(8'h83); ticks(6);
    expect_out(0, 0, "R2 R9 plain write of enable bit does not arm");
    wr(8'h83);
    wr(8'h03);
    ticks(4);
    expect_out(0, 0, "R6 N=3 no expiry at tick 4");
    ticks(1);
    expect_out(0, 1, "R6 R7 N=3 irq at tick 5");
    ticks(3);
    expect_out(0, 1, "R8 irq held through ticks");

    wr(8'h23);
    expect_out(0, 1, "R9 half sequence leaves irq");
    wr(8'h03);
    expect_out(0, 0, "R4 restart clears irq");

    ticks(4); wr(8'h23); wr(8'h03); ticks(4);
    expect_out(0, 0, "R4 restart keeps watchdog alive");
    ticks(1);
    expect_out(0, 1, "R6 expiry 5 ticks after restart");

    wr(8'h43); wr(8'h03);
    expect_out(0, 0, "R3 disable clears irq");
    ticks(20);
    expect_out(0, 0, "R5 no counting while disabled");

    mode_rst = 1'b1;
    wr(8'h80); wr(8'h00);
    ticks(1);
    expect_out(0, 0, "R6 N=0 no expiry at tick 1");
    ticks(1);
    expect_out(1, 0, "R6 R7 N=0 reset request at tick 2");

    wr(8'h20); wr(8'h00);
    expect_out(0, 0, "R4 restart clears reset request");
    wr(8'hC0); wr(8'h00); ticks(5);
    expect_out(0, 0, "R3 disable wins over enable");

    mode_rst = 1'b0;
    wr(8'h9F); wr(8'h1F);
    ticks(32);
    expect_out(0, 0, "R6 N=31 no expiry at tick 32");
    ticks(1);
    expect_out(0, 1, "R6 N=31 irq at tick 33");

    wr(8'h23);
    step(1'b1, 8'h03, 1'b1);
    expect_out(0, 0, "R4 restart beats same-cycle tick");
    ticks(4);
    expect_out(0, 0, "R4 full window after colliding restart");
    ticks(1);
    expect_out(0, 1, "R6 expiry after colliding restart");
    mode_rst = 1'b1;
    ticks(2);
    expect_out(0, 1, "R7 later mode change does not move request");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule